// File: doc/BRIEF.md
# Remappable Two-Half Program Memory

This block is an 8 KB on-chip program memory organised as two 4 KB halves. Each half carries one 12-bit tag that names the 4 KB region of external program space it stands in for. It also keeps one valid flag per 16-byte line, giving 256 lines per half. An instruction fetch hits a half when the upper address bits equal that half's tag and the addressed line is valid. When the tag matches but the line is not yet valid, the block fetches the four words of that line from an external port, marks the line valid and then answers the fetch.

Software retargets a half by writing a new tag to it. That write invalidates every line of the half at once, so the half refills lazily from the new region. A fetch whose tag matches neither half comes back as a ramset miss, so that a different path can serve it. Once every line of a half is valid, a per-half flag reports that the half is filled.

Top module: `ramset_mem`

## Requirements
- R1: After reset, fetch_ready_o is 1, rsp_valid_o, rsp_miss_o and ext_req_o are 0, filled_o is 0, and rsp_valid_o and rsp_miss_o are never high together.
- R2: A byte address splits into tag [23:12], line index [11:4] and word select [3:2]. A fetch accepted while fetch_ready_o is 1 that matches a half's tag on a valid line raises rsp_valid_o in the next cycle, with the stored word.
- R3: An accepted fetch whose tag equals neither half's tag raises rsp_miss_o in the next cycle and issues no external request.
- R4: A fetch whose tag matches a half on an invalid line reads the line from the external port at the line-aligned byte addresses +0, +4, +8 and +12, in that order, one word per ext_ack_i cycle. fetch_ready_o stays 0 until the response.
- R5: One cycle after the fourth word is taken, rsp_valid_o returns the requested word, as supplied by the external port. Later fetches to that line hit without external traffic.
- R6: A tag write to a half (tag_sel_i 0 or 1) invalidates all of that half's lines from the next cycle on, and leaves the other half's lines as they were.
- R7: When both halves hold the matching tag, half 0 serves the fetch, including the fill.
- R8: filled_o[h] is 1 exactly when all 256 lines of half h are valid, and it drops in the cycle after a tag write to h.
- R9: A tag write presented while fetch_ready_o is 0 (a fill in progress) is ignored.
- R10: While ext_req_o is 1 and ext_ack_i is 0, the request and ext_addr_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Fetch request, taken when fetch_ready_o is 1 |
| fetch_addr_i | input | 24 | Fetch byte address |
| fetch_ready_o | output | 1 | Block can accept a fetch or a tag write |
| rsp_valid_o | output | 1 | Fetch answered with data |
| rsp_miss_o | output | 1 | Fetch tag matched no half |
| rsp_data_o | output | 32 | Returned word |
| tag_we_i | input | 1 | Load a new tag into a half |
| tag_sel_i | input | 1 | Half chosen by the tag write |
| tag_i | input | 12 | New tag value |
| filled_o | output | 2 | Per-half all-lines-valid flag |
| ext_req_o | output | 1 | External word read request |
| ext_addr_o | output | 24 | External byte address |
| ext_ack_i | input | 1 | External word delivered this cycle |
| ext_data_i | input | 32 | External read data |

## Verification
The assertions rely on ext_ack_i being raised only while ext_req_o is high. They also rely on a tag write never arriving in the same cycle as an accepted fetch: the lookup in that cycle uses the old tag, and a fill it starts would mark a line valid under the new tag. The bench drives ext_ack_i from a responder that answers only an active request, sometimes after stall cycles. It issues tag writes in their own cycles, apart from fetches. It also presents one tag write deliberately during a fill, to show that the write is dropped.

// File: rtl/ramset_pkg.sv
package ramset_pkg;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OFF_W  = 4;
  localparam int unsigned IDX_W  = 8;
  localparam int unsigned HALVES = 2;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_FILL = 2'd1,
    FS_RESP = 2'd2
  } fill_state_e;
endpackage

// File: rtl/ramset_half.sv
module ramset_half #(
  parameter int unsigned TAG_W  = 12,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned WSEL_W = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tag_we_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  logic [IDX_W-1:0]  lk_idx_i,
  input  logic [WSEL_W-1:0] lk_wsel_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WSEL_W-1:0] wr_wsel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              set_valid_i,
  output logic              tag_match_o,
  output logic              line_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              filled_o
);
  localparam int unsigned LINES = 2 ** IDX_W;
  localparam int unsigned WORDS = LINES * (2 ** WSEL_W);

  logic [TAG_W-1:0]  tag_q;
  logic [LINES-1:0]  valid_q;
  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tag_q <= '0;
    else if (tag_we_i) tag_q <= tag_i;
  end

  // a tag load wins over a line set in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (tag_we_i) valid_q <= '0;
    else if (set_valid_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[{wr_idx_i, wr_wsel_i}] <= wr_data_i;
  end

  assign tag_match_o  = (lk_tag_i == tag_q);
  assign line_valid_o = valid_q[lk_idx_i];
  assign rd_data_o    = mem_q[{lk_idx_i, lk_wsel_i}];
  assign filled_o     = &valid_q;
endmodule

// File: rtl/ramset_fill.sv
module ramset_fill
  import ramset_pkg::*;
#(
  parameter int unsigned LBASE_W = 20,
  parameter int unsigned WSEL_W  = 2,
  parameter int unsigned HSEL_W  = 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [LBASE_W-1:0]        base_i,
  input  logic [WSEL_W-1:0]         wsel_i,
  input  logic [HSEL_W-1:0]         half_i,
  input  logic                      ext_ack_i,
  output logic                      busy_o,
  output logic                      resp_o,
  output logic                      ext_req_o,
  output logic [LBASE_W+WSEL_W+1:0] ext_addr_o,
  output logic                      wr_en_o,
  output logic [WSEL_W-1:0]         wr_wsel_o,
  output logic                      last_o,
  output logic [LBASE_W-1:0]        base_o,
  output logic [WSEL_W-1:0]         wsel_o,
  output logic [HSEL_W-1:0]         half_o
);
  fill_state_e       state_q;
  logic [WSEL_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      cnt_q   <= '0;
      base_o  <= '0;
      wsel_o  <= '0;
      half_o  <= '0;
    end else begin
      unique case (state_q)
        FS_IDLE: if (start_i) begin
          state_q <= FS_FILL;
          cnt_q   <= '0;
          base_o  <= base_i;
          wsel_o  <= wsel_i;
          half_o  <= half_i;
        end
        FS_FILL: if (ext_ack_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == '1) state_q <= FS_RESP;
        end
        FS_RESP: state_q <= FS_IDLE;
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != FS_IDLE);
  assign resp_o     = (state_q == FS_RESP);
  assign ext_req_o  = (state_q == FS_FILL);
  assign ext_addr_o = {base_o, cnt_q, 2'b00};
  assign wr_en_o    = ext_req_o && ext_ack_i;
  assign wr_wsel_o  = cnt_q;
  assign last_o     = wr_en_o && (cnt_q == '1);
endmodule

// File: rtl/ramset_mem.sv
module ramset_mem
  import ramset_pkg::*;
#(
  parameter int unsigned P_ADDR_W = ADDR_W,
  parameter int unsigned P_DATA_W = DATA_W,
  parameter int unsigned P_OFF_W  = OFF_W,
  parameter int unsigned P_IDX_W  = IDX_W,
  parameter int unsigned P_HALVES = HALVES,
  localparam int unsigned TAG_W   = P_ADDR_W - P_IDX_W - P_OFF_W,
  localparam int unsigned WSEL_W  = P_OFF_W - 2,
  localparam int unsigned LBASE_W = P_ADDR_W - P_OFF_W,
  localparam int unsigned HSEL_W  = (P_HALVES > 1) ? $clog2(P_HALVES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fetch_req_i,
  input  logic [P_ADDR_W-1:0] fetch_addr_i,
  output logic                fetch_ready_o,
  output logic                rsp_valid_o,
  output logic                rsp_miss_o,
  output logic [P_DATA_W-1:0] rsp_data_o,
  input  logic                tag_we_i,
  input  logic [HSEL_W-1:0]   tag_sel_i,
  input  logic [TAG_W-1:0]    tag_i,
  output logic [P_HALVES-1:0] filled_o,
  output logic                ext_req_o,
  output logic [P_ADDR_W-1:0] ext_addr_o,
  input  logic                ext_ack_i,
  input  logic [P_DATA_W-1:0] ext_data_i
);
  logic                busy, resp_now, fill_wr, fill_last, accept, start, tag_load;
  logic [WSEL_W-1:0]   fill_wsel, held_wsel;
  logic [LBASE_W-1:0]  held_base;
  logic [HSEL_W-1:0]   held_half, sel_half;
  logic [P_ADDR_W-1:0] lk_addr;
  logic [TAG_W-1:0]    lk_tag;
  logic [P_IDX_W-1:0]  lk_idx;
  logic [WSEL_W-1:0]   lk_wsel;
  logic [P_HALVES-1:0] match, lvalid;
  logic [P_DATA_W-1:0] rdata [P_HALVES];
  logic                any_match, sel_valid;
  logic [P_DATA_W-1:0] sel_data;

  assign fetch_ready_o = !busy;
  assign accept        = fetch_req_i && !busy;
  assign tag_load      = tag_we_i && !busy;

  // during the response cycle the lookup replays the held fill address
  assign lk_addr = resp_now ? {held_base, held_wsel, 2'b00} : fetch_addr_i;
  assign lk_tag  = lk_addr[P_ADDR_W-1 -: TAG_W];
  assign lk_idx  = lk_addr[P_OFF_W +: P_IDX_W];
  assign lk_wsel = lk_addr[2 +: WSEL_W];

  for (genvar h = 0; h < P_HALVES; h++) begin : g_half
    ramset_half #(
      .TAG_W (TAG_W),
      .IDX_W (P_IDX_W),
      .WSEL_W(WSEL_W),
      .DATA_W(P_DATA_W)
    ) u_half (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tag_we_i    (tag_load && (tag_sel_i == HSEL_W'(h))),
      .tag_i       (tag_i),
      .lk_tag_i    (lk_tag),
      .lk_idx_i    (lk_idx),
      .lk_wsel_i   (lk_wsel),
      .wr_en_i     (fill_wr && (held_half == HSEL_W'(h))),
      .wr_idx_i    (held_base[P_IDX_W-1:0]),
      .wr_wsel_i   (fill_wsel),
      .wr_data_i   (ext_data_i),
      .set_valid_i (fill_last && (held_half == HSEL_W'(h))),
      .tag_match_o (match[h]),
      .line_valid_o(lvalid[h]),
      .rd_data_o   (rdata[h]),
      .filled_o    (filled_o[h])
    );
  end

  // lowest-numbered matching half wins
  always_comb begin
    sel_half  = '0;
    sel_valid = 1'b0;
    sel_data  = rdata[0];
    any_match = 1'b0;
    for (int h = P_HALVES - 1; h >= 0; h--) begin
      if (match[h]) begin
        sel_half  = HSEL_W'(h);
        sel_valid = lvalid[h];
        sel_data  = rdata[h];
        any_match = 1'b1;
      end
    end
  end

  assign start = accept && any_match && !sel_valid;

  ramset_fill #(
    .LBASE_W(LBASE_W),
    .WSEL_W (WSEL_W),
    .HSEL_W (HSEL_W)
  ) u_fill (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .base_i    (fetch_addr_i[P_ADDR_W-1:P_OFF_W]),
    .wsel_i    (fetch_addr_i[2 +: WSEL_W]),
    .half_i    (sel_half),
    .ext_ack_i (ext_ack_i),
    .busy_o    (busy),
    .resp_o    (resp_now),
    .ext_req_o (ext_req_o),
    .ext_addr_o(ext_addr_o),
    .wr_en_o   (fill_wr),
    .wr_wsel_o (fill_wsel),
    .last_o    (fill_last),
    .base_o    (held_base),
    .wsel_o    (held_wsel),
    .half_o    (held_half)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= resp_now || (accept && any_match && sel_valid);
      rsp_miss_o  <= accept && !any_match;
      if (resp_now || (accept && sel_valid)) rsp_data_o <= sel_data;
    end
  end
endmodule

module ramset_mem_chk #(
  parameter int unsigned A_W = 24,
  parameter int unsigned O_W = 4,
  parameter int unsigned H_N = 2,
  parameter int unsigned S_W = 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           fetch_req_i,
  input logic           fetch_ready_o,
  input logic           rsp_valid_o,
  input logic           rsp_miss_o,
  input logic           tag_we_i,
  input logic [S_W-1:0] tag_sel_i,
  input logic [H_N-1:0] filled_o,
  input logic           ext_req_o,
  input logic [A_W-1:0] ext_addr_o,
  input logic           ext_ack_i
);
  // R1
  rsp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && rsp_miss_o));
  // R2
  fetch_answer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_i && fetch_ready_o |=> rsp_valid_o || rsp_miss_o || ext_req_o);
  // R3
  miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |-> !ext_req_o);
  // R4
  fill_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o |-> !fetch_ready_o && ext_addr_o[1:0] == 2'b00);
  // R4
  fill_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o && ext_ack_i && ext_addr_o[O_W-1:2] != '1
    |=> ext_req_o && ext_addr_o == $past(ext_addr_o) + A_W'(4));
  // R5
  fill_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o && ext_ack_i && ext_addr_o[O_W-1:2] == '1
    |=> !ext_req_o ##1 (rsp_valid_o && !rsp_miss_o));
  // R6
  tag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we_i && fetch_ready_o |=> !filled_o[$past(tag_sel_i)]);
  // R10
  ext_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o && !ext_ack_i |=> ext_req_o && $stable(ext_addr_o));
endmodule

bind ramset_mem ramset_mem_chk #(
  .A_W(P_ADDR_W),
  .O_W(P_OFF_W),
  .H_N(P_HALVES),
  .S_W(HSEL_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_req_i  (fetch_req_i),
  .fetch_ready_o(fetch_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_miss_o   (rsp_miss_o),
  .tag_we_i     (tag_we_i),
  .tag_sel_i    (tag_sel_i),
  .filled_o     (filled_o),
  .ext_req_o    (ext_req_o),
  .ext_addr_o   (ext_addr_o),
  .ext_ack_i    (ext_ack_i)
);

// File: tb/tb_ramset_mem.sv
module tb_ramset_mem;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0;
  logic [23:0] fetch_addr = '0;
  logic        fetch_ready, rsp_valid, rsp_miss;
  logic [31:0] rsp_data;
  logic        tag_we = 1'b0;
  logic        tag_sel = 1'b0;
  logic [11:0] tag_val = '0;
  logic [1:0]  filled;
  logic        ext_req;
  logic [23:0] ext_addr;
  logic        ext_ack = 1'b0;
  logic [31:0] ext_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  int stall = 0;
  int ext_n = 0;
  logic [23:0] ext_log [16];

  always #4 clk = ~clk;

  ramset_mem dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_i(fetch_req), .fetch_addr_i(fetch_addr), .fetch_ready_o(fetch_ready),
    .rsp_valid_o(rsp_valid), .rsp_miss_o(rsp_miss), .rsp_data_o(rsp_data),
    .tag_we_i(tag_we), .tag_sel_i(tag_sel), .tag_i(tag_val), .filled_o(filled),
    .ext_req_o(ext_req), .ext_addr_o(ext_addr), .ext_ack_i(ext_ack), .ext_data_i(ext_data)
  );

  function automatic logic [31:0] model(input logic [23:0] a);
    return {8'hC3, a} ^ {a[15:0], 16'h0};
  endfunction

  // external memory responder
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (ext_req) begin
        if (wait_cnt >= stall) begin
          ext_ack = 1'b1;
          ext_data = model(ext_addr);
          if (ext_n < 16) ext_log[ext_n] = ext_addr;
          ext_n++;
          wait_cnt = 0;
        end else begin
          ext_ack = 1'b0;
          wait_cnt++;
        end
      end else begin
        ext_ack = 1'b0;
        wait_cnt = 0;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic write_tag(input logic sel, input logic [11:0] t);
    @(negedge clk);
    while (!fetch_ready) @(negedge clk);
    tag_we = 1'b1; tag_sel = sel; tag_val = t;
    @(negedge clk);
    tag_we = 1'b0;
  endtask

  task automatic do_fetch(input logic [23:0] a, output logic [31:0] d, output logic miss,
                          output int words, output int lat);
    @(negedge clk);
    while (!fetch_ready) @(negedge clk);
    ext_n = 0;
    fetch_req = 1'b1; fetch_addr = a;
    lat = 0;
    @(negedge clk);
    fetch_req = 1'b0;
    lat = 1;
    while (!(rsp_valid || rsp_miss) && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    d = rsp_data; miss = rsp_miss; words = ext_n;
  endtask

  task automatic t_reset();
    check(fetch_ready === 1'b1, "R1 ready", 32'(fetch_ready), 1);
    check(rsp_valid === 1'b0 && rsp_miss === 1'b0, "R1 rsp", {rsp_valid, rsp_miss}, 0);
    check(ext_req === 1'b0, "R1 ext_req", 32'(ext_req), 0);
    check(filled === 2'b00, "R1 filled", 32'(filled), 0);
  endtask

  task automatic t_miss();
    logic [31:0] d; logic m; int w, l;
    write_tag(1'b0, 12'h123);
    write_tag(1'b1, 12'h456);
    do_fetch(24'h789000, d, m, w, l);
    check(m && l == 1, "R3 miss flag", {m, 8'(l)}, {1'b1, 8'd1});
    check(w == 0, "R3 no ext", w, 0);
  endtask

  task automatic t_fill();
    logic [31:0] d; logic m; int w, l;
    stall = 2;
    do_fetch(24'h1230A8, d, m, w, l);
    check(w == 4, "R4 word count", w, 4);
    for (int i = 0; i < 4; i++)
      check(ext_log[i] == 24'h1230A0 + 24'(4 * i), "R10 R4 ext order", ext_log[i], 24'h1230A0 + 24'(4 * i));
    check(!m && d == model(24'h1230A8), "R5 fill data", d, model(24'h1230A8));
    stall = 0;
    do_fetch(24'h1230AC, d, m, w, l);
    check(l == 1 && w == 0, "R2 hit latency", {8'(l), 8'(w)}, {8'd1, 8'd0});
    check(d == model(24'h1230AC), "R2 hit data", d, model(24'h1230AC));
    do_fetch(24'h456FF4, d, m, w, l);
    check(w == 4 && d == model(24'h456FF4), "R5 half1 fill", d, model(24'h456FF4));
  endtask

  task automatic t_remap();
    logic [31:0] d; logic m; int w, l;
    write_tag(1'b0, 12'h124);
    do_fetch(24'h1230AC, d, m, w, l);
    check(m, "R6 old region miss", 32'(m), 1);
    do_fetch(24'h456FF4, d, m, w, l);
    check(!m && w == 0 && d == model(24'h456FF4), "R6 other half kept", w, 0);
    write_tag(1'b0, 12'h123);
    do_fetch(24'h1230AC, d, m, w, l);
    check(w == 4 && d == model(24'h1230AC), "R6 lines cleared", w, 4);
  endtask

  task automatic t_priority();
    logic [31:0] d; logic m; int w, l;
    write_tag(1'b0, 12'h200);
    write_tag(1'b1, 12'h200);
    do_fetch(24'h200010, d, m, w, l);
    check(w == 4 && d == model(24'h200010), "R7 first fill", w, 4);
    write_tag(1'b0, 12'h301);
    do_fetch(24'h200010, d, m, w, l);
    check(w == 4, "R7 fill went to half0", w, 4);
  endtask

  task automatic t_busy_tag();
    logic [31:0] d; logic m; int w, l;
    write_tag(1'b0, 12'h123);
    stall = 3;
    @(negedge clk);
    while (!fetch_ready) @(negedge clk);
    fetch_req = 1'b1; fetch_addr = 24'h123100;
    @(negedge clk);
    fetch_req = 1'b0;
    tag_we = 1'b1; tag_sel = 1'b0; tag_val = 12'h777;
    @(negedge clk);
    tag_we = 1'b0;
    l = 0;
    while (!rsp_valid && l < 60) begin
      @(negedge clk);
      l++;
    end
    check(rsp_valid && rsp_data == model(24'h123100), "R9 fill unharmed", rsp_data, model(24'h123100));
    stall = 0;
    do_fetch(24'h123100, d, m, w, l);
    check(!m && w == 0, "R9 tag write ignored", {m, 8'(w)}, 0);
    do_fetch(24'h777000, d, m, w, l);
    check(m, "R9 new tag not loaded", 32'(m), 1);
  endtask

  task automatic t_filled();
    logic [31:0] d; logic m; int w, l;
    write_tag(1'b1, 12'h0AB);
    check(filled[1] == 1'b0, "R8 empty", 32'(filled), 0);
    for (int i = 0; i < 256; i++) begin
      do_fetch({12'h0AB, 8'(i), 4'h0}, d, m, w, l);
      if (i == 254) check(filled[1] == 1'b0, "R8 one line short", 32'(filled[1]), 0);
    end
    @(negedge clk);
    check(filled[1] == 1'b1, "R8 all valid", 32'(filled[1]), 1);
    write_tag(1'b1, 12'h0AC);
    check(filled[1] == 1'b0, "R8 R6 cleared by tag write", 32'(filled[1]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss();
    t_fill();
    t_remap();
    t_priority();
    t_busy_tag();
    t_filled();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule